// File: doc/BRIEF.md
# Serial Pattern-Unlock Access Controller

This block sits between a host memory bus and a byte-wide SRAM and hides a small serial register file behind it. It watches the chip-enable, output-enable and write-enable strobes and bit 0 of the data bus. All of them are synchronised to the system clock. A bus cycle counts once, when chip enable returns high. A cycle is a read when output enable was active. It is a write when only write enable was active.

A read cycle arms the lock and points it at bit 0 of a key set by parameter. Each following write presents one key bit on DQ0, with bit 0 compared first. A correct bit advances the pointer. A wrong bit latches the lock shut until the next read. A read in the middle of the key rewinds the attempt.

When every key bit has matched, the next transfer cycles go to the register file instead of the RAM. A write stores DQ0 into the bit selected by the cycle's position. A read drives that bit out on DQ0. The RAM chip enable is held off for the whole transfer. After the last transfer cycle the block locks again.

Top module: `pattern_unlock_ctrl`

## Requirements
- R1: After reset the block is locked and the register file holds all zeros. `ram_ce_n` follows `bus_ce_n`, `dq0_oe` is 0 and `unlocked` is 0.
- R2: While no read cycle has armed the lock, write cycles have no effect, even when their data equals the key.
- R3: Once armed, a write whose DQ0 equals key bit p (p starting at 0) advances p. After KEY_BITS consecutive matching writes, `unlocked` goes to 1.
- R4: A write whose DQ0 differs from key bit p latches the lock shut. No later write has any effect until a read cycle occurs.
- R5: A read cycle while locked, at any point in the key, restarts matching at key bit 0.
- R6: Bus activity with `bus_ce_n` high disturbs neither the key matching nor the transfer sequence.
- R7: While `unlocked` is 1, `ram_ce_n` is held at 1 regardless of `bus_ce_n`.
- R8: The n-th transfer cycle after unlocking (n from 0) addresses register bit n. If that cycle is a write, DQ0 is stored there.
- R9: During a transfer read cycle, `dq0_oe` is 1 and `dq0_out` carries register bit n. `dq0_oe` is 0 whenever the block is locked.
- R10: After REG_BITS transfer cycles, reads and writes alike, the block locks again and RAM access returns.
- R11: A low level on `hold_rst_n` while a key is being matched cancels the attempt if register bit RSTEN_BIT is 0. It is ignored if that bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| dq0_in | input | 1 | Data bit 0 from the host |
| hold_rst_n | input | 1 | External reset pin that can cancel matching |
| ram_ce_n | output | 1 | Gated chip enable to the SRAM |
| dq0_oe | output | 1 | Drive enable for data bit 0 |
| dq0_out | output | 1 | Register bit driven on data bit 0 |
| unlocked | output | 1 | High during the transfer phase |

## Verification
The bench builds the block with KEY_BITS and REG_BITS both set to 16, the key 16'hC5A3 and RSTEN_BIT at 0. The shorter key and file let full unlock, write-back and read-back sequences run many times. They include aborts part-way through the key, a mismatch followed by otherwise correct bits, and deselected cycles mixed into both phases. Placing the reset-enable flag at bit 0 lets a single transfer write choose whether a pulse on the reset pin cancels matching.

// File: rtl/puc_pkg.sv
// Shared types for the pattern-unlock controller.
package puc_pkg;
    // Lock phases: unarmed, matching key bits, latched mismatch, transfer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_FAIL  = 2'd2,
        ST_XFER  = 2'd3
    } puc_state_e;
endpackage

// File: rtl/puc_sync.sv
// Multi-stage synchroniser for a vector of asynchronous bus inputs.
// Assumes each bit is independent; the reset value is chosen per bit.
module puc_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/puc_cycle_detect.sv
// Turns synchronised strobes into one event per bus cycle, raised when chip
// enable deasserts. It assumes the strobes were stable during the last clock
// of the cycle. A read wins when both enables were low.
module puc_cycle_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s,
    input  logic oe_s,
    input  logic we_s,
    input  logic dq_s,
    output logic evt_read,
    output logic evt_write,
    output logic evt_data
);
    logic ce_prev, oe_prev, we_prev, dq_prev;

    // Keep the previous strobe and data levels for edge classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_prev <= 1'b1;
            oe_prev <= 1'b1;
            we_prev <= 1'b1;
            dq_prev <= 1'b0;
        end else begin
            ce_prev <= ce_s;
            oe_prev <= oe_s;
            we_prev <= we_s;
            dq_prev <= dq_s;
        end
    end

    // Classify the cycle that just ended.
    always_comb begin
        evt_read  = ce_s && !ce_prev && !oe_prev;
        evt_write = ce_s && !ce_prev && oe_prev && !we_prev;
        evt_data  = dq_prev;
    end
endmodule

// File: rtl/puc_lock_fsm.sv
// Key matcher and transfer sequencer. It walks the key one bit per write,
// latches on a mismatch, and rewinds on a read. After a full match it counts
// REG_BITS transfer cycles. Assumes at most one bus event per clock.
module puc_lock_fsm
    import puc_pkg::*;
#(
    parameter int                 KEY_BITS = 64,
    parameter logic [KEY_BITS-1:0] KEY     = 64'h5CA3_3AC5_5CA3_3AC5,
    parameter int                 REG_BITS = 64,
    localparam int                KP_W     = $clog2(KEY_BITS),
    localparam int                XP_W     = $clog2(REG_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_read,
    input  logic             evt_write,
    input  logic             evt_data,
    input  logic             pin_rst_s,
    input  logic             rst_enable_bit,
    output puc_state_e       state,
    output logic [XP_W-1:0]  xfer_ptr,
    output logic             xfer_wr
);
    localparam logic [KP_W-1:0] KEY_LAST  = KP_W'(KEY_BITS - 1);
    localparam logic [XP_W-1:0] XFER_LAST = XP_W'(REG_BITS - 1);

    logic [KP_W-1:0] key_ptr;
    logic            cancel;

    // A low reset pin cancels matching when the register flag allows it.
    assign cancel  = !pin_rst_s && !rst_enable_bit;
    assign xfer_wr = (state == ST_XFER) && evt_write;

    // Advance the lock state on each completed bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            key_ptr  <= '0;
            xfer_ptr <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_FAIL: begin
                    if (evt_read) begin
                        state   <= ST_MATCH;
                        key_ptr <= '0;
                    end
                end
                ST_MATCH: begin
                    if (evt_read) begin
                        key_ptr <= '0;
                    end else if (cancel) begin
                        state   <= ST_IDLE;
                        key_ptr <= '0;
                    end else if (evt_write) begin
                        if (evt_data == KEY[key_ptr]) begin
                            if (key_ptr == KEY_LAST) begin
                                state    <= ST_XFER;
                                key_ptr  <= '0;
                                xfer_ptr <= '0;
                            end else begin
                                key_ptr <= key_ptr + 1'b1;
                            end
                        end else begin
                            state <= ST_FAIL;
                        end
                    end
                end
                default: begin
                    if (evt_read || evt_write) begin
                        if (xfer_ptr == XFER_LAST) begin
                            state    <= ST_IDLE;
                            xfer_ptr <= '0;
                        end else begin
                            xfer_ptr <= xfer_ptr + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    AST_IDLE_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !evt_read) |=> (state == ST_IDLE)); // R2
    AST_UNLOCK_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_XFER) |-> $past(state == ST_MATCH && evt_write && key_ptr == KEY_LAST)); // R3
    AST_FAIL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAIL && !evt_read) |=> (state == ST_FAIL)); // R4
    AST_READ_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_read && state != ST_XFER) |=> (state == ST_MATCH && key_ptr == '0)); // R5
    AST_RELOCK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && xfer_ptr == XFER_LAST && (evt_read || evt_write)) |=> (state == ST_IDLE)); // R10
    AST_CANCEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MATCH && !evt_read && cancel) |=> (state == ST_IDLE)); // R11
endmodule

// File: rtl/puc_regfile.sv
// Bit-addressed serial register file. One bit is written per transfer write.
// The bit at the current transfer position is offered for reads. Assumes the
// index is always below REG_BITS.
module puc_regfile #(
    parameter int  REG_BITS  = 64,
    parameter int  RSTEN_BIT = 4,
    localparam int XP_W      = $clog2(REG_BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XP_W-1:0] idx,
    input  logic            wdata,
    output logic            rdata,
    output logic            rst_enable_bit
);
    logic [REG_BITS-1:0] bits;

    // Store the written bit at the transfer position.
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else if (wr_en) bits[idx] <= wdata;
    end

    assign rdata          = bits[idx];
    assign rst_enable_bit = bits[RSTEN_BIT];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bits[$past(idx)] == $past(wdata))); // R8
endmodule

// File: rtl/pattern_unlock_ctrl.sv
// Top level: synchronises the host strobes, detects bus cycles, runs the key
// lock, and gates the SRAM chip enable and the DQ0 driver. Assumes the host
// holds each strobe for at least STAGES+1 clocks.
module pattern_unlock_ctrl
    import puc_pkg::*;
#(
    parameter int                  KEY_BITS  = 64,
    parameter logic [KEY_BITS-1:0] KEY       = 64'h5CA3_3AC5_5CA3_3AC5,
    parameter int                  REG_BITS  = 64,
    parameter int                  RSTEN_BIT = 4,
    parameter int                  STAGES    = 2,
    localparam int                 XP_W      = $clog2(REG_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_ce_n,
    input  logic bus_oe_n,
    input  logic bus_we_n,
    input  logic dq0_in,
    input  logic hold_rst_n,
    output logic ram_ce_n,
    output logic dq0_oe,
    output logic dq0_out,
    output logic unlocked
);
    logic [4:0]      sync_q;
    logic            evt_read, evt_write, evt_data;
    logic            rst_enable_bit, xfer_wr, rd_bit;
    logic [XP_W-1:0] xfer_ptr;
    puc_state_e      state;

    puc_sync #(.W(5), .STAGES(STAGES), .RST_VAL(5'b11101)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({hold_rst_n, bus_ce_n, bus_oe_n, dq0_in, bus_we_n}),
        .q (sync_q)
    );

    puc_cycle_detect u_cyc (
        .clk (clk),
        .rst_n (rst_n),
        .ce_s (sync_q[3]),
        .oe_s (sync_q[2]),
        .we_s (sync_q[0]),
        .dq_s (sync_q[1]),
        .evt_read (evt_read),
        .evt_write (evt_write),
        .evt_data (evt_data)
    );

    puc_lock_fsm #(.KEY_BITS(KEY_BITS), .KEY(KEY), .REG_BITS(REG_BITS)) u_fsm (
        .clk (clk),
        .rst_n (rst_n),
        .evt_read (evt_read),
        .evt_write (evt_write),
        .evt_data (evt_data),
        .pin_rst_s (sync_q[4]),
        .rst_enable_bit (rst_enable_bit),
        .state (state),
        .xfer_ptr (xfer_ptr),
        .xfer_wr (xfer_wr)
    );

    puc_regfile #(.REG_BITS(REG_BITS), .RSTEN_BIT(RSTEN_BIT)) u_regs (
        .clk (clk),
        .rst_n (rst_n),
        .wr_en (xfer_wr),
        .idx (xfer_ptr),
        .wdata (evt_data),
        .rdata (rd_bit),
        .rst_enable_bit (rst_enable_bit)
    );

    // Gate the RAM and the DQ0 driver by the lock phase.
    always_comb begin
        unlocked = (state == ST_XFER);
        ram_ce_n = bus_ce_n | unlocked;
        dq0_oe   = unlocked & ~bus_ce_n & ~bus_oe_n;
        dq0_out  = rd_bit;
    end

    AST_NO_DRIVE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_XFER) |-> !dq0_oe); // R9
endmodule

// File: tb/pattern_unlock_ctrl_test.sv
module pattern_unlock_ctrl_test;
    localparam int          KB   = 16;
    localparam logic [15:0] KEYV = 16'hC5A3;
    localparam logic [15:0] W1   = 16'h9E34;   // bit 0 = 0: reset pin may cancel
    localparam logic [15:0] W2   = 16'h61CB;   // bit 0 = 1: reset pin ignored

    localparam logic [1:0] K_RD = 2'd0, K_OK = 2'd1, K_BAD = 2'd2, K_NSEL = 2'd3;
    typedef struct packed { logic [1:0] kind; logic [7:0] count; logic exp; } vec_t;
    localparam vec_t TABLE [12] = '{
        '{K_OK, 8'd16, 1'b0},  // R2 unarmed writes
        '{K_RD, 8'd1,  1'b0},
        '{K_OK, 8'd4,  1'b0},
        '{K_BAD, 8'd1, 1'b0},  // R4
        '{K_OK, 8'd11, 1'b0},
        '{K_RD, 8'd1,  1'b0},
        '{K_OK, 8'd7,  1'b0},
        '{K_RD, 8'd1,  1'b0},  // R5 abort
        '{K_OK, 8'd9,  1'b0},
        '{K_NSEL, 8'd3, 1'b0}, // R6
        '{K_OK, 8'd6,  1'b0},
        '{K_OK, 8'd1,  1'b1}   // R3
    };

    logic clk = 0, rst_n = 0;
    logic bus_ce_n = 1, bus_oe_n = 1, bus_we_n = 1, dq0_in = 0, hold_rst_n = 1;
    logic ram_ce_n, dq0_oe, dq0_out, unlocked;
    logic mid_ram, mid_oe, mid_out;
    int n_chk = 0, n_fail = 0;
    int kidx = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pattern_unlock_ctrl #(.KEY_BITS(KB), .KEY(KEYV), .REG_BITS(16), .RSTEN_BIT(0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .dq0_in(dq0_in), .hold_rst_n(hold_rst_n),
        .ram_ce_n(ram_ce_n), .dq0_oe(dq0_oe), .dq0_out(dq0_out), .unlocked(unlocked)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One bus cycle: sel drives chip enable, rd picks read or write.
    task automatic bus_cycle(input bit sel, input bit rd, input bit dbit);
        @(negedge clk);
        bus_ce_n = !sel;
        if (rd) bus_oe_n = 0; else begin bus_we_n = 0; dq0_in = dbit; end
        repeat (4) @(negedge clk);
        mid_ram = ram_ce_n; mid_oe = dq0_oe; mid_out = dq0_out;
        bus_ce_n = 1; bus_oe_n = 1; bus_we_n = 1;
        repeat (6) @(negedge clk);
    endtask

    task automatic unlock();
        bus_cycle(1, 1, 0);
        for (int i = 0; i < KB; i++) bus_cycle(1, 0, KEYV[i]);
        check("R3 unlock", unlocked, 1);
    endtask

    task automatic pin_pulse();
        @(negedge clk); hold_rst_n = 0;
        repeat (4) @(negedge clk); hold_rst_n = 1;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_all(input logic [15:0] exp, input string tag);
        for (int i = 0; i < 16; i++) begin
            bus_cycle(1, 1, 0);
            check({tag, " R9 drive"}, mid_oe, 1);
            check({tag, " R8 bit"}, mid_out, exp[i]);
            check("R7 ram off", mid_ram, 1);
        end
        check("R10 relock", unlocked, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 locked", unlocked, 0);
        check("R1 no drive", dq0_oe, 0);
        check("R1 ram idle", ram_ce_n, 1);

        // Table walk over matching scenarios.
        foreach (TABLE[t]) begin
            for (int r = 0; r < int'(TABLE[t].count); r++) begin
                case (TABLE[t].kind)
                    K_RD:   begin bus_cycle(1, 1, 0); kidx = 0; end
                    K_OK:   begin bus_cycle(1, 0, KEYV[kidx % KB]); kidx++; end
                    K_BAD:  begin bus_cycle(1, 0, !KEYV[kidx % KB]); kidx++; end
                    default: bus_cycle(0, 0, !KEYV[kidx % KB]);
                endcase
                if (TABLE[t].kind != K_NSEL) check("R1 ram follows", mid_ram, 0);
                else check("R6 ram idle", mid_ram, 1);
                if (TABLE[t].kind == K_RD) check("R9 locked read", mid_oe, 0);
                check("R3 state", unlocked, (r == int'(TABLE[t].count) - 1) ? TABLE[t].exp : 1'b0);
            end
        end

        // Transfer writes of W1, with a deselected cycle mixed in.
        for (int i = 0; i < 16; i++) begin
            if (i == 7) bus_cycle(0, 0, !W1[i]);
            bus_cycle(1, 0, W1[i]);
            check("R7 ram off", mid_ram, 1);
            check("R10 count", unlocked, (i == 15) ? 1'b0 : 1'b1);
        end
        bus_cycle(1, 1, 0);
        check("R9 locked read", mid_oe, 0);
        check("R10 ram back", mid_ram, 0);

        unlock();
        read_all(W1, "W1");

        // R11: flag bit is 0, pin pulse cancels matching.
        bus_cycle(1, 1, 0);
        for (int i = 0; i < 5; i++) bus_cycle(1, 0, KEYV[i]);
        pin_pulse();
        for (int i = 5; i < KB; i++) bus_cycle(1, 0, KEYV[i]);
        check("R11 cancel", unlocked, 0);

        unlock();
        for (int i = 0; i < 16; i++) bus_cycle(1, 0, W2[i]);
        check("R10 relock", unlocked, 0);

        // R11: flag bit is 1, pin pulse ignored.
        bus_cycle(1, 1, 0);
        for (int i = 0; i < 5; i++) bus_cycle(1, 0, KEYV[i]);
        pin_pulse();
        for (int i = 5; i < KB; i++) bus_cycle(1, 0, KEYV[i]);
        check("R11 no cancel", unlocked, 1);
        read_all(W2, "W2");

        // R1: reset while unlocked relocks and clears the file.
        unlock();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R1 reset relock", unlocked, 0);
        unlock();
        read_all(16'h0000, "R1 cleared");

        finish_run();
    end
endmodule